// File: doc/BRIEF.md
# Pin-Window Microsequencer

This block is a very small 8-bit sequencer that services one window of eight pins taken from a 64-pin bank. It steps through a program of 12-bit words held in a single-port instruction memory. The program moves data between sixteen internal byte registers, combines them with simple bitwise logic, shifts pin samples into a register, and shifts register bits out to the pins. Serial bit streams can therefore be assembled or produced one pin-bit at a time.

The program is written through a load port while the core is halted. Raising `run` starts execution at the current program address. Dropping `run` lets the instruction in flight finish, and the core then parks. The core places its pin drive onto the bank as an OR contribution. `orIn` carries the drive of the cores earlier in the chain, `orOut` passes on the combined drive, and several cores chained this way form a wired-OR onto the same 64 pins.

Top module: `pinlet_core`

## Requirements
- R1: While `rstN` is low, and after it is released, all sixteen registers, the window group, the output latch and the program address are zero, and the core is halted. In this state `orOut` equals `orIn`.
- R2: While the core is halted, a cycle with `loadEn` high writes `loadData` into instruction word `loadAddr`.
- R3: Each instruction takes exactly three clocks (fetch, execute, result), and its effects become visible after the result clock. When `run` is low at the end of a result clock, the core halts and keeps its program address. Raising `run` again resumes at that address.
- R4: An instruction word holds the opcode in bits [11:8], the destination register `d` in bits [7:4] and the field `f` in bits [3:0]. Opcode 0x0 and opcodes 0xC to 0xF do nothing. Opcode 0x1 sets `d = {d[3:0], f}`. Opcode 0x2 copies register `f` into `d`.
- R5: With register `f` as the source, opcode 0x3 sets `d = d & f`, opcode 0x4 sets `d = d | f`, opcode 0x5 sets `d = d ^ f`, and opcode 0x6 sets `d = d & ~f`.
- R6: Opcode 0x7 sets `d = {d[6:0], p}`, where `p` is window pin `f[2:0]` (bank pin 8*g + f[2:0]) of `pinIn`, taken through a two-flop synchronizer.
- R7: Opcode 0x8 loads output latch bit `f[2:0]` with `d[7]` and then shifts `d` left by one. The other latch bits keep their values.
- R8: Opcode 0x9 sets the window group `g` to `f[2:0]`. If `g` changes, all eight latch bits are cleared. If `g` stays the same, the latch is kept.
- R9: For every pin, `orOut[8*g+i]` equals `orIn[8*g+i] | latch[i]`. Every pin outside the window passes `orIn` through unchanged.
- R10: Opcode 0xA jumps to the address in bits [7:0]. Opcode 0xB jumps to `{pc[7:4], f}` (where `pc` is the address of that instruction) when register `d` is zero. In every other case the address increments, wrapping from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Execute while high; halt after the current instruction when low |
| loadEn | input | 1 | Write strobe for the instruction memory, accepted while halted |
| loadAddr | input | 8 | Instruction memory write address |
| loadData | input | 12 | Instruction word to write |
| pinIn | input | 64 | Raw pin levels of the bank |
| orIn | input | 64 | Drive contributions of upstream cores |
| orOut | output | 64 | `orIn` ORed with this core's window drive |

## Verification
The hardest situations to reach from the ports are the ones that depend on internal register contents and on the program address: the conditional jump must see a register that is zero on one pass and non-zero on the next, and the address must wrap from 255 back to 0. The stimulus loads a program that jumps to the top of memory, falls through the last word into address 0, and re-runs the conditional jump after a register has been set. Register values that are never seen directly are shifted out to the window pins, so the register state becomes visible on `orOut`. A halt is requested in the middle of an instruction, and the pins are watched to confirm that the instruction finishes and that nothing then moves until `run` returns.

// File: rtl/pinlet_pkg.sv
package pinlet_pkg;
  localparam int DATA_W   = 8;   // datapath and register width
  localparam int NUM_REGS = 16;
  localparam int REG_AW   = $clog2(NUM_REGS);
  localparam int INSTR_W  = 12;
  localparam int WIN_PINS = 8;
  localparam int PSEL_W   = $clog2(WIN_PINS);

  typedef enum logic [3:0] {
    OP_NOP  = 4'h0,
    OP_LDN  = 4'h1,
    OP_MOV  = 4'h2,
    OP_AND  = 4'h3,
    OP_OR   = 4'h4,
    OP_XOR  = 4'h5,
    OP_ANDN = 4'h6,
    OP_SHI  = 4'h7,
    OP_SHO  = 4'h8,
    OP_WIN  = 4'h9,
    OP_JMP  = 4'hA,
    OP_JZ   = 4'hB
  } opcode_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FETCH  = 2'd1,
    PH_EXEC   = 2'd2,
    PH_RESULT = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              capture;  // execute phase: form result
    logic              commit;   // result phase: write state
    logic [3:0]        op;
    logic [REG_AW-1:0] rd;
    logic [3:0]        fld;
  } strobe_t;
endpackage

// File: rtl/pinlet_imem.sv
module pinlet_imem #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // single port: one address, write or registered read
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/pinlet_ctrl.sv
module pinlet_ctrl
  import pinlet_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               run,
  input  logic               loadEn,
  input  logic [PC_W-1:0]    loadAddr,
  input  logic [INSTR_W-1:0] instr,
  input  logic               rdZero,
  output logic               memWe,
  output logic [PC_W-1:0]    memAddr,
  output strobe_t            strb,
  output phase_e             phase,
  output logic [PC_W-1:0]    pcQ
);
  logic            halted;
  logic            takeJump;
  logic [PC_W-1:0] jumpTarget;
  logic [3:0]      opField;

  assign halted  = (phase == PH_IDLE);
  assign memWe   = halted & loadEn;
  assign memAddr = halted ? loadAddr : pcQ;
  assign opField = instr[11:8];

  assign strb.capture = (phase == PH_EXEC);
  assign strb.commit  = (phase == PH_RESULT);
  assign strb.op      = opField;
  assign strb.rd      = instr[7:4];
  assign strb.fld     = instr[3:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      pcQ        <= '0;
      takeJump   <= 1'b0;
      jumpTarget <= '0;
    end else begin
      unique case (phase)
        PH_IDLE:  if (run) phase <= PH_FETCH;
        PH_FETCH: phase <= PH_EXEC;
        PH_EXEC: begin
          phase      <= PH_RESULT;
          takeJump   <= (opField == OP_JMP) || ((opField == OP_JZ) && rdZero);
          jumpTarget <= (opField == OP_JMP) ? PC_W'(instr[7:0])
                                            : {pcQ[PC_W-1:4], instr[3:0]};
        end
        PH_RESULT: begin
          pcQ   <= takeJump ? jumpTarget : pcQ + 1'b1;
          phase <= run ? PH_FETCH : PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pinlet_dpath.sv
module pinlet_dpath
  import pinlet_pkg::*;
#(
  parameter int PIN_COUNT = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [PIN_COUNT-1:0] orIn,
  output logic [PIN_COUNT-1:0] orOut,
  output logic                 rdZero,
  output logic [$clog2(PIN_COUNT/WIN_PINS)-1:0] winBase,
  output logic [WIN_PINS-1:0]  outLatch
);
  localparam int GROUPS = PIN_COUNT / WIN_PINS;
  localparam int GRP_W  = $clog2(GROUPS);

  logic [DATA_W-1:0]    regs [NUM_REGS];
  logic [PIN_COUNT-1:0] syncA, syncB;
  logic [DATA_W-1:0]    resQ, rdVal, rsVal, aluNext;
  logic [PSEL_W-1:0]    pinSel;
  logic [GRP_W-1:0]     winNext;
  logic                 winPin, writesReg;
  logic [PIN_COUNT-1:0] contrib;

  assign rdVal   = regs[strb.rd];
  assign rsVal   = regs[strb.fld];
  assign rdZero  = (rdVal == '0);
  assign pinSel  = strb.fld[PSEL_W-1:0];
  assign winNext = strb.fld[GRP_W-1:0];
  assign winPin  = syncB[{winBase, pinSel}];

  always_comb begin
    writesReg = 1'b1;
    aluNext   = rdVal;
    case (strb.op)
      OP_LDN:  aluNext = {rdVal[3:0], strb.fld};
      OP_MOV:  aluNext = rsVal;
      OP_AND:  aluNext = rdVal & rsVal;
      OP_OR:   aluNext = rdVal | rsVal;
      OP_XOR:  aluNext = rdVal ^ rsVal;
      OP_ANDN: aluNext = rdVal & ~rsVal;
      OP_SHI:  aluNext = {rdVal[DATA_W-2:0], winPin};
      OP_SHO:  aluNext = {rdVal[DATA_W-2:0], 1'b0};
      default: writesReg = 1'b0;
    endcase
  end

  // two-flop synchronizer on the whole bank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      resQ     <= '0;
      winBase  <= '0;
      outLatch <= '0;
    end else begin
      if (strb.capture) resQ <= aluNext;
      if (strb.commit) begin
        if (writesReg) regs[strb.rd] <= resQ;
        if (strb.op == OP_SHO) outLatch[pinSel] <= rdVal[DATA_W-1];
        if (strb.op == OP_WIN && winNext != winBase) begin
          winBase  <= winNext;
          outLatch <= '0;
        end
      end
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : gGrp
    assign contrib[g*WIN_PINS +: WIN_PINS] =
      (winBase == GRP_W'(g)) ? outLatch : '0;
  end

  assign orOut = orIn | contrib;
endmodule

// File: rtl/pinlet_core.sv
module pinlet_core
  import pinlet_pkg::*;
#(
  parameter int PIN_COUNT = 64,
  parameter int PC_W      = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 run,
  input  logic                 loadEn,
  input  logic [PC_W-1:0]      loadAddr,
  input  logic [INSTR_W-1:0]   loadData,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [PIN_COUNT-1:0] orIn,
  output logic [PIN_COUNT-1:0] orOut
);
  localparam int GRP_W = $clog2(PIN_COUNT / WIN_PINS);

  strobe_t            strb;
  phase_e             phase;
  logic [PC_W-1:0]    pcQ, memAddr;
  logic [INSTR_W-1:0] instr;
  logic               memWe, rdZero;
  logic [GRP_W-1:0]   winBase;
  logic [WIN_PINS-1:0] outLatch;

  pinlet_imem #(.ADDR_W(PC_W), .WORD_W(INSTR_W)) u_imem (
    .clk(clk), .we(memWe), .addr(memAddr), .wdata(loadData), .rdata(instr)
  );

  pinlet_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .loadEn(loadEn), .loadAddr(loadAddr),
    .instr(instr), .rdZero(rdZero), .memWe(memWe), .memAddr(memAddr),
    .strb(strb), .phase(phase), .pcQ(pcQ)
  );

  pinlet_dpath #(.PIN_COUNT(PIN_COUNT)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .pinIn(pinIn), .orIn(orIn),
    .orOut(orOut), .rdZero(rdZero), .winBase(winBase), .outLatch(outLatch)
  );
endmodule

// File: rtl/pinlet_checker.sv
module pinlet_checker
  import pinlet_pkg::*;
#(
  parameter int PIN_COUNT = 64,
  parameter int PC_W      = 8,
  parameter int GRP_W     = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 run,
  input logic [PIN_COUNT-1:0] orIn,
  input logic [PIN_COUNT-1:0] orOut,
  input logic [1:0]           phase,
  input logic [PC_W-1:0]      pcQ,
  input logic [GRP_W-1:0]     winBase,
  input logic [WIN_PINS-1:0]  outLatch
);
  logic [PIN_COUNT-1:0] winMask;
  assign winMask = {{(PIN_COUNT-WIN_PINS){1'b0}}, {WIN_PINS{1'b1}}} << (winBase * WIN_PINS);

  a_r3_fetch_to_exec: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_FETCH |=> phase == PH_EXEC);

  a_r3_exec_to_result: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_EXEC |=> phase == PH_RESULT);

  a_r3_halt_holds: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && !run) |=> (phase == PH_IDLE && $stable(pcQ)));

  a_r9_upstream_kept: assert property (@(posedge clk) disable iff (!rstN)
    (orOut & orIn) == orIn);

  a_r9_outside_window: assert property (@(posedge clk) disable iff (!rstN)
    (orOut & ~orIn & ~winMask) == '0);

  a_r8_latch_clear: assert property (@(posedge clk) disable iff (!rstN)
    (winBase != $past(winBase)) |-> (outLatch == '0));
endmodule

bind pinlet_core pinlet_checker #(
  .PIN_COUNT(PIN_COUNT), .PC_W(PC_W), .GRP_W(GRP_W)
) u_chk (
  .clk(clk), .rstN(rstN), .run(run), .orIn(orIn), .orOut(orOut),
  .phase(phase), .pcQ(pcQ), .winBase(winBase), .outLatch(outLatch)
);

// File: tb/sim_pinlet_core.sv
module sim_pinlet_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0, run = 1'b0, loadEn = 1'b0;
  logic [7:0]  loadAddr = '0;
  logic [11:0] loadData = '0;
  logic [63:0] pinIn = '0, orIn = '0;
  logic [63:0] orOut;

  always #2.5 clk = ~clk;  // 200 MHz

  pinlet_core u0 (.clk(clk), .rstN(rstN), .run(run), .loadEn(loadEn),
    .loadAddr(loadAddr), .loadData(loadData), .pinIn(pinIn), .orIn(orIn),
    .orOut(orOut));

  int    errors = 0, checks = 0;
  string curReq = "R1";
  bit    cmpOn = 0, done = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [11:0] bimem [256];
  logic [7:0]  mr [16];
  logic [7:0]  mpc, mlatch;
  logic [2:0]  mbase;
  logic [63:0] ms1, ms2, s2old;
  logic        mpin;
  int          mph;

  task automatic modelExec(logic [11:0] w);
    logic [3:0] op, d, f;
    logic [7:0] nxt;
    op = w[11:8]; d = w[7:4]; f = w[3:0]; nxt = mpc + 8'd1;
    case (op)
      4'h1: mr[d] = {mr[d][3:0], f};
      4'h2: mr[d] = mr[f];
      4'h3: mr[d] = mr[d] & mr[f];
      4'h4: mr[d] = mr[d] | mr[f];
      4'h5: mr[d] = mr[d] ^ mr[f];
      4'h6: mr[d] = mr[d] & ~mr[f];
      4'h7: mr[d] = {mr[d][6:0], mpin};
      4'h8: begin mlatch[f[2:0]] = mr[d][7]; mr[d] = mr[d] << 1; end
      4'h9: if (f[2:0] != mbase) begin mbase = f[2:0]; mlatch = '0; end
      4'hA: nxt = w[7:0];
      4'hB: if (mr[d] == 8'h00) nxt = {mpc[7:4], f};
      default: ;
    endcase
    mpc = nxt;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mr[i] = '0;
      mpc = '0; mlatch = '0; mbase = '0; ms1 = '0; ms2 = '0; mph = 0; mpin = 0;
    end else begin
      s2old = ms2; ms2 = ms1; ms1 = pinIn;
      case (mph)
        0: if (run) mph = 1;
        1: mph = 2;
        2: begin mpin = s2old[mbase*8 + int'(bimem[mpc][2:0])]; mph = 3; end
        default: begin modelExec(bimem[mpc]); mph = run ? 1 : 0; end
      endcase
    end
  end

  function automatic logic [63:0] modelOut();
    return orIn | ({56'b0, mlatch} << (mbase * 8));
  endfunction

  always @(negedge clk) if (rstN && cmpOn && !done) chk(curReq, orOut, modelOut());

  // ---------------- stimulus helpers ----------------
  int progPtr;

  task automatic doReset();
    cmpOn = 0; rstN = 0; run = 0;
    repeat (3) @(negedge clk);
    rstN = 1; @(negedge clk);
    cmpOn = 1; progPtr = 0;
  endtask

  task automatic emit(logic [11:0] w);
    loadEn = 1; loadAddr = progPtr[7:0]; loadData = w; bimem[progPtr] = w;
    @(negedge clk);
    loadEn = 0; progPtr++;
  endtask

  task automatic put(int a, logic [11:0] w);
    progPtr = a; emit(w);
  endtask

  task automatic runFor(int n);
    run = 1; repeat (n) @(negedge clk);
    run = 0; repeat (5) @(negedge clk);
  endtask

  task automatic progSerialOut();  // r1 = 0xA5 then shifted to pins 0..7
    progPtr = 0;
    emit(12'h11A); emit(12'h115); emit(12'hC00);
    for (int i = 0; i < 8; i++) emit(12'h810 | 12'(i));
    emit(12'hA0B);
  endtask

  logic [63:0] held;

  initial begin
    // R1 reset state
    orIn = 64'h1234_5678_9ABC_DEF0;
    rstN = 0; repeat (2) @(negedge clk);
    chk("R1 during reset", orOut, orIn);
    doReset();
    repeat (4) @(negedge clk);
    chk("R1 after reset", orOut, 64'h1234_5678_9ABC_DEF0);
    orIn = '0;

    // R2, R4, R7: load while halted, nibble loads, serial out
    curReq = "R7"; doReset(); progSerialOut();
    curReq = "R2"; runFor(80);
    chk("R2/R4/R7 byte A5 on pins", orOut, 64'h0000_0000_0000_00A5);

    // R3: halt mid-program, then resume
    curReq = "R3"; doReset(); progSerialOut();
    run = 1; repeat (13) @(negedge clk); run = 0;
    repeat (4) @(negedge clk);
    held = orOut;
    repeat (8) @(negedge clk);
    chk("R3 stable while halted", orOut, held);
    chk("R3 partial progress", orOut, 64'h0000_0000_0000_0001);
    runFor(80);
    chk("R3 resumed to completion", orOut, 64'h0000_0000_0000_00A5);

    // R5: logic operations, results shifted out to window 0
    curReq = "R5"; doReset(); progPtr = 0;
    emit(12'h123); emit(12'h12C); emit(12'h130); emit(12'h13F);
    emit(12'h242); emit(12'h343);
    emit(12'h252); emit(12'h453);
    emit(12'h262); emit(12'h563);
    emit(12'h272); emit(12'h673);
    for (int r = 4; r < 8; r++)
      for (int i = 0; i < 8; i++) emit(12'h800 | 12'(r << 4) | 12'(i));
    emit(12'hA00 | 12'(progPtr));
    runFor(200);
    chk("R5 ANDN 3C,0F reversed on pins", orOut, 64'h0000_0000_0000_000C);

    // R8: window select, same-group keep, change clears
    curReq = "R8"; doReset(); progPtr = 0;
    emit(12'h903); emit(12'h11F); emit(12'h11F);
    for (int i = 0; i < 4; i++) emit(12'h810 | 12'(i));
    emit(12'h903); emit(12'h905); emit(12'h817); emit(12'hA0A);
    run = 1; repeat (3*7 + 2) @(negedge clk);
    chk("R8 low nibble on group 3", orOut, 64'h0000_0000_0F00_0000);
    repeat (3) @(negedge clk);
    chk("R8 same group keeps latch", orOut, 64'h0000_0000_0F00_0000);
    repeat (3) @(negedge clk);
    chk("R8 new group clears latch", orOut, 64'h0);
    run = 0; repeat (5) @(negedge clk);
    runFor(40);
    chk("R8 drive on pin 47", orOut, 64'h0000_8000_0000_0000);

    // R6: shift in from window 2 through synchronizer
    curReq = "R6"; pinIn = 64'hFFFF_FFFF_FF6B_FFFF;
    doReset(); progPtr = 0;
    emit(12'h902);
    for (int i = 0; i < 8; i++) emit(12'h740 | 12'(i));
    for (int i = 0; i < 8; i++) emit(12'h840 | 12'(i));
    emit(12'hA11);
    runFor(80);
    chk("R6 sampled byte 6B back on pins", orOut, 64'h0000_0000_006B_0000);
    pinIn = '0;

    // R10 and R9: conditional jump, wrap 255->0, OR with upstream
    curReq = "R10"; orIn = 64'hF000_0000_0000_0000;
    doReset();
    put(0, 12'hB68); put(1, 12'h17F); put(2, 12'h17F); put(3, 12'h870);
    put(4, 12'hA04); put(8, 12'h161); put(9, 12'hAFE);
    put(254, 12'h000); put(255, 12'hF00);
    runFor(60);
    chk("R10 jump, wrap and second pass", orOut, 64'hF000_0000_0000_0001);
    curReq = "R9"; orIn = 64'h0F0F_0000_0000_0000;
    @(negedge clk);
    chk("R9 upstream ORed outside window", orOut, 64'h0F0F_0000_0000_0001);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule